// File: doc/BRIEF.md
# Windowed Register File with Save and Restore

This block is the integer register file of a processor that gives each procedure a fresh register window. Every window sees 32 logical registers split into four groups of eight: shared globals (r0 to r7), outgoing arguments (r8 to r15), private locals (r16 to r23) and incoming arguments (r24 to r31). The windows form a ring.

Each window owns 16 physical registers, its locals and its ins. Its outs are the ins of the next window in the ring, so a caller hands arguments to its callee without copying them. The physical store holds 8 + 16 × NWIN registers, where NWIN runs from 2 to 32.

The pipeline drives two read ports and one write port with 5-bit logical numbers. A save command moves the current window pointer forward by one and a restore command moves it back by one. In the cycle that carries either command, both reads come from the window that was current before the command, and the write goes into the window the pointer moves to. This lets a single operation read its operands in the caller's frame and deposit the result in the callee's frame, or the reverse.

Two counters track how many further saves and restores are legal. A command that would exceed them is refused and raises a trap pulse for the handler logic. Spilling and filling windows to memory is left to that handler.

Top module: `winreg_file`

## Requirements
- R1: While rst_n is low and after it is released, cur_win is 0, both trap outputs are 0 and every logical register of every window reads 0. The save budget starts at NWIN-2 and the restore budget starts at 0.
- R2: Logical registers 1 to 7 map to the same eight physical globals in every window. A value written in one window reads back unchanged in another.
- R3: After an accepted save, the new window's incoming registers r24+k (k = 0..7) read the values the old window held in its outgoing registers r8+k.
- R4: Local registers r16 to r23 are private to each window. A write to a local in one window is not seen in the locals of any other window.
- R5: Logical register 0 always reads 0 on both ports, and a write to it has no effect.
- R6: An accepted save (save_req=1) reads both operands from the current window and writes into window cur_win+1 (modulo NWIN). It sets cur_win to that window at the next edge and moves one unit from the save budget to the restore budget.
- R7: An accepted restore (restore_req=1, save_req=0) reads from the current window and writes into window cur_win-1 (modulo NWIN). It sets cur_win to that window at the next edge and moves one unit back from the restore budget to the save budget.
- R8: A save issued while the save budget is 0 is refused. ovf_trap is 1 for exactly the following cycle, cur_win does not change, and the write of that cycle is discarded.
- R9: A restore issued while the restore budget is 0 is refused. unf_trap is 1 for exactly the following cycle, cur_win does not change, and the write of that cycle is discarded.
- R10: When a read port addresses the physical register being written in the same cycle, that port returns wr_data (write-first).
- R11: When save_req and restore_req are both 1, the cycle behaves as a save and the restore request is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| save_req | input | 1 | Advance to the next window this cycle |
| restore_req | input | 1 | Return to the previous window this cycle |
| rd_a_idx | input | 5 | Logical register for read port A |
| rd_a_data | output | DW | Read port A data (combinational) |
| rd_b_idx | input | 5 | Logical register for read port B |
| rd_b_data | output | DW | Read port B data (combinational) |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Logical register to write |
| wr_data | input | DW | Write data |
| cur_win | output | $clog2(NWIN) | Current window pointer |
| ovf_trap | output | 1 | One-cycle pulse after a refused save |
| unf_trap | output | 1 | One-cycle pulse after a refused restore |

## Verification
The assertions run on every cycle and check the pointer. It steps forward or back by exactly one ring position on an accepted command and holds otherwise. The checker keeps its own depth counter to confirm that the traps fire at, and only at, the budget limits and leave the pointer in place. The assertions also cover register 0 reading zero and write-first forwarding on plain cycles. Window overlap, the privacy of locals, the use of the old window for reads and the new window for writes during save and restore, and the discarding of writes in refused cycles all depend on stored contents. Only the bench's reference model, compared every cycle, can show these.

// File: rtl/winreg_pkg.sv
// Package: shared constants and types for the windowed register file.
// Assumes a 32-entry logical name space split into four groups of eight.
package winreg_pkg;
    localparam int LIDX_W   = 5;   // logical register number width
    localparam int GRP_SIZE = 8;   // registers per group
    localparam int NUM_GLB  = 8;   // physical globals at the bottom of the store
    localparam int WIN_REGS = 16;  // unique physical registers per window

    typedef logic [LIDX_W-1:0] lidx_t;

    // Command seen by the window controller in one cycle.
    typedef enum logic [1:0] {
        CMD_NONE    = 2'd0,
        CMD_SAVE    = 2'd1,
        CMD_RESTORE = 2'd2
    } wcmd_e;
endpackage

// File: rtl/winreg_map.sv
// Module: translates a logical register number plus a window number into
// a physical index. Layout: globals at 0..7, then per window w a block of
// 16 starting at 8+16*w (locals first, ins second). Outs of window w are
// the ins of window (w+1) mod NWIN. Purely combinational.
module winreg_map
    import winreg_pkg::*;
#(
    parameter int NWIN = 8,
    parameter int WW   = $clog2(NWIN),
    parameter int PW   = 8
) (
    input  lidx_t         lidx,
    input  logic [WW-1:0] win,
    output logic [PW-1:0] pidx
);
    logic [WW-1:0] nxt_win;
    int            blk_base;
    int            nxt_base;

    // Compute the ring successor and the base of both window blocks.
    always_comb begin
        nxt_win  = (win == WW'(NWIN - 1)) ? '0 : win + 1'b1;
        blk_base = NUM_GLB + WIN_REGS * int'(win);
        nxt_base = NUM_GLB + WIN_REGS * int'(nxt_win);
    end

    // Select the physical slot by logical group.
    always_comb begin
        unique case (lidx[4:3])
            2'b00:   pidx = PW'(int'(lidx));
            2'b01:   pidx = PW'(nxt_base + GRP_SIZE + int'(lidx[2:0]));
            2'b10:   pidx = PW'(blk_base + int'(lidx[2:0]));
            default: pidx = PW'(blk_base + GRP_SIZE + int'(lidx[2:0]));
        endcase
    end
endmodule

// File: rtl/winreg_ctrl.sv
// Module: window pointer and save/restore budget control. Decides whether
// a command is accepted, gives the window the write lands in, and drives
// registered one-cycle trap pulses for refused commands.
// Assumes save has priority when both requests are raised.
module winreg_ctrl
    import winreg_pkg::*;
#(
    parameter int NWIN = 8,
    parameter int WW   = $clog2(NWIN),
    parameter int CW   = $clog2(NWIN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          save_req,
    input  logic          restore_req,
    output logic [WW-1:0] cur_win,
    output logic [WW-1:0] wr_win,
    output logic          wr_block,
    output logic          ovf_trap,
    output logic          unf_trap
);
    logic [CW-1:0] can_save;
    logic [CW-1:0] can_rest;
    wcmd_e         cmd;
    logic          save_ok, rest_ok;
    logic [WW-1:0] win_inc, win_dec;

    // Resolve the command of this cycle with save taking priority.
    always_comb begin
        if (save_req)         cmd = CMD_SAVE;
        else if (restore_req) cmd = CMD_RESTORE;
        else                  cmd = CMD_NONE;
    end

    // Ring neighbours of the current window and command acceptance.
    always_comb begin
        win_inc  = (cur_win == WW'(NWIN - 1)) ? '0 : cur_win + 1'b1;
        win_dec  = (cur_win == '0) ? WW'(NWIN - 1) : cur_win - 1'b1;
        save_ok  = (cmd == CMD_SAVE)    && (can_save != '0);
        rest_ok  = (cmd == CMD_RESTORE) && (can_rest != '0);
        wr_block = ((cmd == CMD_SAVE) && !save_ok) || ((cmd == CMD_RESTORE) && !rest_ok);
        if (save_ok)      wr_win = win_inc;
        else if (rest_ok) wr_win = win_dec;
        else              wr_win = cur_win;
    end

    // Update pointer, budgets and trap pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_win  <= '0;
            can_save <= CW'(NWIN - 2);
            can_rest <= '0;
            ovf_trap <= 1'b0;
            unf_trap <= 1'b0;
        end else begin
            ovf_trap <= (cmd == CMD_SAVE)    && !save_ok;
            unf_trap <= (cmd == CMD_RESTORE) && !rest_ok;
            if (save_ok) begin
                cur_win  <= win_inc;
                can_save <= can_save - 1'b1;
                can_rest <= can_rest + 1'b1;
            end else if (rest_ok) begin
                cur_win  <= win_dec;
                can_save <= can_save + 1'b1;
                can_rest <= can_rest - 1'b1;
            end
        end
    end
endmodule

// File: rtl/winreg_store.sv
// Module: physical register array with NRD combinational read ports and one
// write port. A read of the slot being written returns the new data.
// Assumes the caller never enables a write to slot 0.
module winreg_store #(
    parameter int NREG = 136,
    parameter int PW   = 8,
    parameter int DW   = 32,
    parameter int NRD  = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [PW-1:0]            wr_pidx,
    input  logic [DW-1:0]            wr_data,
    input  logic [NRD-1:0][PW-1:0]   rd_pidx,
    output logic [NRD-1:0][DW-1:0]   rd_data
);
    logic [DW-1:0] mem [NREG];

    // Clear the array on reset, otherwise store the write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) mem[i] <= '0;
        end else if (we) begin
            mem[wr_pidx] <= wr_data;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        // Read port p with write-first forwarding.
        always_comb begin
            if (we && (wr_pidx == rd_pidx[p])) rd_data[p] = wr_data;
            else                               rd_data[p] = mem[rd_pidx[p]];
        end
    end
endmodule

// File: rtl/winreg_file.sv
// Module: top of the windowed register file. Maps the two read and one write
// logical indices to physical slots: reads use the current window and the
// write uses the window chosen by the controller. Writes to r0 and writes in
// a refused save/restore cycle are dropped.
module winreg_file
    import winreg_pkg::*;
#(
    parameter int NWIN = 8,
    parameter int DW   = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    save_req,
    input  logic                    restore_req,
    input  logic [4:0]              rd_a_idx,
    output logic [DW-1:0]           rd_a_data,
    input  logic [4:0]              rd_b_idx,
    output logic [DW-1:0]           rd_b_data,
    input  logic                    wr_en,
    input  logic [4:0]              wr_idx,
    input  logic [DW-1:0]           wr_data,
    output logic [$clog2(NWIN)-1:0] cur_win,
    output logic                    ovf_trap,
    output logic                    unf_trap
);
    localparam int WW   = $clog2(NWIN);
    localparam int NREG = NUM_GLB + WIN_REGS * NWIN;
    localparam int PW   = $clog2(NREG);
    localparam int NRD  = 2;
    localparam int NLK  = NRD + 1;   // lookups: read ports then the write port

    logic [WW-1:0]            wr_win;
    logic                     wr_block;
    logic                     we_eff;
    lidx_t [NLK-1:0]          lk_idx;
    logic  [NLK-1:0][WW-1:0]  lk_win;
    logic  [NLK-1:0][PW-1:0]  lk_pidx;
    logic  [NRD-1:0][PW-1:0]  rd_pidx;
    logic  [NRD-1:0][DW-1:0]  rd_data;

    winreg_ctrl #(.NWIN(NWIN), .WW(WW), .CW(WW)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .save_req    (save_req),
        .restore_req (restore_req),
        .cur_win     (cur_win),
        .wr_win      (wr_win),
        .wr_block    (wr_block),
        .ovf_trap    (ovf_trap),
        .unf_trap    (unf_trap)
    );

    // Gather the lookup requests: reads in the old window, write in the new.
    always_comb begin
        lk_idx[0] = rd_a_idx;
        lk_idx[1] = rd_b_idx;
        lk_idx[2] = wr_idx;
        lk_win[0] = cur_win;
        lk_win[1] = cur_win;
        lk_win[2] = wr_win;
        we_eff    = wr_en && !wr_block && (wr_idx != '0);
    end

    for (genvar k = 0; k < NLK; k++) begin : g_map
        winreg_map #(.NWIN(NWIN), .WW(WW), .PW(PW)) u_map (
            .lidx (lk_idx[k]),
            .win  (lk_win[k]),
            .pidx (lk_pidx[k])
        );
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rp
        assign rd_pidx[p] = lk_pidx[p];
    end

    winreg_store #(.NREG(NREG), .PW(PW), .DW(DW), .NRD(NRD)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (we_eff),
        .wr_pidx (lk_pidx[NRD]),
        .wr_data (wr_data),
        .rd_pidx (rd_pidx),
        .rd_data (rd_data)
    );

    assign rd_a_data = rd_data[0];
    assign rd_b_data = rd_data[1];
endmodule

// File: rtl/winreg_file_chk.sv
// Module: property checker for winreg_file, bound to every instance.
// Keeps its own call-depth counter to judge when traps must occur.
module winreg_file_chk #(
    parameter int NWIN = 8,
    parameter int DW   = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    save_req,
    input  logic                    restore_req,
    input  logic [4:0]              rd_a_idx,
    input  logic [DW-1:0]           rd_a_data,
    input  logic [4:0]              rd_b_idx,
    input  logic [DW-1:0]           rd_b_data,
    input  logic                    wr_en,
    input  logic [4:0]              wr_idx,
    input  logic [DW-1:0]           wr_data,
    input  logic [$clog2(NWIN)-1:0] cur_win,
    input  logic                    ovf_trap,
    input  logic                    unf_trap
);
    localparam int WW  = $clog2(NWIN);
    localparam int LIM = NWIN - 2;

    int            depth;
    logic [WW-1:0] exp_inc, exp_dec;

    // Independent count of accepted saves minus accepted restores.
    always_ff @(posedge clk) begin
        if (!rst_n) depth <= 0;
        else if (save_req && depth != LIM) depth <= depth + 1;
        else if (!save_req && restore_req && depth != 0) depth <= depth - 1;
    end

    // Ring neighbours of the pointer as seen at the ports.
    always_comb begin
        exp_inc = (cur_win == WW'(NWIN - 1)) ? '0 : cur_win + 1'b1;
        exp_dec = (cur_win == '0) ? WW'(NWIN - 1) : cur_win - 1'b1;
    end

    a_r5_zero_a: assert property (@(posedge clk) disable iff (!rst_n)
        rd_a_idx == 5'd0 |-> rd_a_data == '0);
    a_r5_zero_b: assert property (@(posedge clk) disable iff (!rst_n)
        rd_b_idx == 5'd0 |-> rd_b_data == '0);
    a_r6_save_step: assert property (@(posedge clk) disable iff (!rst_n)
        save_req && depth != LIM |=> cur_win == $past(exp_inc));
    a_r7_restore_step: assert property (@(posedge clk) disable iff (!rst_n)
        !save_req && restore_req && depth != 0 |=> cur_win == $past(exp_dec));
    a_r8_ovf_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
        save_req && depth == LIM |=> ovf_trap && cur_win == $past(cur_win));
    a_r8_ovf_only_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
        !(save_req && depth == LIM) |=> !ovf_trap);
    a_r9_unf_at_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !save_req && restore_req && depth == 0 |=> unf_trap && cur_win == $past(cur_win));
    a_r9_unf_only_at_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !(!save_req && restore_req && depth == 0) |=> !unf_trap);
    a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !save_req && !restore_req |=> $stable(cur_win));
    a_r10_bypass_a: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !save_req && !restore_req && wr_idx != 5'd0 && wr_idx == rd_a_idx
        |-> rd_a_data == wr_data);
    a_r10_bypass_b: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !save_req && !restore_req && wr_idx != 5'd0 && wr_idx == rd_b_idx
        |-> rd_b_data == wr_data);
endmodule

bind winreg_file winreg_file_chk #(.NWIN(NWIN), .DW(DW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .save_req    (save_req),
    .restore_req (restore_req),
    .rd_a_idx    (rd_a_idx),
    .rd_a_data   (rd_a_data),
    .rd_b_idx    (rd_b_idx),
    .rd_b_data   (rd_b_data),
    .wr_en       (wr_en),
    .wr_idx      (wr_idx),
    .wr_data     (wr_data),
    .cur_win     (cur_win),
    .ovf_trap    (ovf_trap),
    .unf_trap    (unf_trap)
);

// File: tb/winreg_file_bench.sv
// Bench: behavioural model of the register windows (per-group arrays and
// counters) compared with the design on every cycle.
module winreg_file_bench;
    localparam int NW = 8;
    localparam int DW = 32;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst_n, save_req, restore_req, wr_en;
    logic [4:0]    rd_a_idx, rd_b_idx, wr_idx;
    logic [DW-1:0] wr_data, rd_a_data, rd_b_data;
    logic [2:0]    cur_win;
    logic          ovf_trap, unf_trap;

    winreg_file #(.NWIN(NW), .DW(DW)) u_winreg_file (
        .clk(clk), .rst_n(rst_n), .save_req(save_req), .restore_req(restore_req),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data), .rd_b_idx(rd_b_idx),
        .rd_b_data(rd_b_data), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .cur_win(cur_win), .ovf_trap(ovf_trap), .unf_trap(unf_trap)
    );

    int checks = 0;
    int fails  = 0;

    logic [DW-1:0] m_glb [8];
    logic [DW-1:0] m_loc [NW][8];
    logic [DW-1:0] m_in  [NW][8];
    int m_w, m_cs, m_cr;
    bit m_ovf, m_unf;

    function automatic logic [DW-1:0] mread(int w, int r);
        if (r == 0)  return '0;
        if (r < 8)   return m_glb[r];
        if (r < 16)  return m_in[(w + 1) % NW][r - 8];
        if (r < 24)  return m_loc[w][r - 16];
        return m_in[w][r - 24];
    endfunction

    // Identity of a storage location, used for the forwarding check.
    function automatic int mkey(int w, int r);
        if (r < 8)  return r;
        if (r < 16) return 2000 + ((w + 1) % NW) * 8 + (r - 8);
        if (r < 24) return 1000 + w * 8 + (r - 16);
        return 2000 + w * 8 + (r - 24);
    endfunction

    task automatic mwrite(int w, int r, logic [DW-1:0] d);
        if (r == 0) return;
        if (r < 8)       m_glb[r] = d;
        else if (r < 16) m_in[(w + 1) % NW][r - 8] = d;
        else if (r < 24) m_loc[w][r - 16] = d;
        else             m_in[w][r - 24] = d;
    endtask

    task automatic chk(string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // One clock: drive, compare design against model, then advance the model.
    task automatic cyc(string tag, bit s, bit r, bit we, int wi, logic [DW-1:0] wd,
                       int ra, int rb);
        bit sv, rs, sok, rok, blk, wen;
        int ww;
        logic [DW-1:0] ea, eb;
        @(negedge clk);
        save_req = s; restore_req = r; wr_en = we;
        wr_idx = 5'(wi); wr_data = wd; rd_a_idx = 5'(ra); rd_b_idx = 5'(rb);
        #2;
        sv  = s;
        rs  = r && !s;
        sok = sv && (m_cs > 0);
        rok = rs && (m_cr > 0);
        blk = (sv && !sok) || (rs && !rok);
        ww  = sok ? (m_w + 1) % NW : (rok ? (m_w + NW - 1) % NW : m_w);
        wen = we && !blk && (wi != 0);
        ea  = (wen && ra != 0 && mkey(ww, wi) == mkey(m_w, ra)) ? wd : mread(m_w, ra);
        eb  = (wen && rb != 0 && mkey(ww, wi) == mkey(m_w, rb)) ? wd : mread(m_w, rb);
        chk(tag, "cur_win",   32'(cur_win),  32'(m_w));
        chk(tag, "ovf_trap",  32'(ovf_trap), 32'(m_ovf));
        chk(tag, "unf_trap",  32'(unf_trap), 32'(m_unf));
        chk(tag, "rd_a_data", rd_a_data, ea);
        chk(tag, "rd_b_data", rd_b_data, eb);
        @(posedge clk);
        if (wen) mwrite(ww, wi, wd);
        m_ovf = sv && !sok;
        m_unf = rs && !rok;
        if (sok) begin m_w = ww; m_cs--; m_cr++; end
        if (rok) begin m_w = ww; m_cs++; m_cr--; end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #4_000_000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        rst_n = 1'b0; save_req = 0; restore_req = 0; wr_en = 0;
        wr_idx = 0; wr_data = 0; rd_a_idx = 0; rd_b_idx = 0;
        for (int i = 0; i < 8; i++) m_glb[i] = '0;
        for (int w = 0; w < NW; w++)
            for (int i = 0; i < 8; i++) begin m_loc[w][i] = '0; m_in[w][i] = '0; end
        m_w = 0; m_cs = NW - 2; m_cr = 0; m_ovf = 0; m_unf = 0;
        repeat (3) @(negedge clk);
        #2;
        chk("R1", "cur_win in reset", 32'(cur_win), 32'd0);
        chk("R1", "traps in reset", 32'({ovf_trap, unf_trap}), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: every logical register reads zero after reset.
        for (int r = 0; r < 32; r += 2) cyc("R1", 0, 0, 0, 0, '0, r, r + 1);

        // R5: write to r0 is dropped.
        cyc("R5", 0, 0, 1, 0, 32'hDEAD_BEEF, 0, 0);
        cyc("R5", 0, 0, 0, 0, '0, 0, 0);

        // R2: globals written in window 0.
        for (int g = 1; g < 8; g++) cyc("R2", 0, 0, 1, g, 32'h1000 + g, 0, 0);
        cyc("R4", 0, 0, 1, 16, 32'hAAAA_0001, 0, 0);
        cyc("R3", 0, 0, 1, 8,  32'hBBBB_0008, 0, 0);
        cyc("R3", 0, 0, 1, 15, 32'hBBBB_000F, 0, 0);

        // R6: save reads old window, writes the new window's local.
        cyc("R6", 1, 0, 1, 16, 32'hCCCC_0010, 16, 8);
        cyc("R3", 0, 0, 0, 0, '0, 24, 31);
        cyc("R4", 0, 0, 0, 0, '0, 16, 1);
        for (int g = 1; g < 8; g++) cyc("R2", 0, 0, 0, 0, '0, g, 0);

        // R7: restore reads callee, writes caller's out.
        cyc("R7", 0, 1, 1, 9, 32'hDDDD_0009, 16, 24);
        cyc("R4", 0, 0, 0, 0, '0, 16, 9);

        // R9: restore with nothing to restore.
        cyc("R9", 0, 1, 1, 17, 32'hEEEE_0011, 17, 0);
        cyc("R9", 0, 0, 0, 0, '0, 17, 0);
        cyc("R9", 0, 0, 0, 0, '0, 17, 16);

        // R8: exhaust the save budget, then a refused save.
        for (int k = 0; k < NW - 2; k++) cyc("R6", 1, 0, 1, 20, 32'h5000 + k, 20, 8);
        cyc("R8", 1, 0, 1, 20, 32'hF0F0_F0F0, 20, 0);
        cyc("R8", 0, 0, 0, 0, '0, 20, 24);
        cyc("R8", 0, 0, 0, 0, '0, 20, 0);

        // R10: write-first forwarding on both ports.
        cyc("R10", 0, 0, 1, 18, 32'h1234_5678, 18, 18);
        cyc("R10", 0, 0, 1, 3, 32'h0BAD_CAFE, 3, 18);
        cyc("R10", 1, 1, 0, 0, '0, 0, 0);

        // R11: both requests with a budget for each -> save wins.
        cyc("R7", 0, 1, 0, 0, '0, 18, 0);
        cyc("R11", 1, 1, 1, 24, 32'h7777_0018, 8, 24);
        cyc("R11", 0, 0, 0, 0, '0, 24, 0);

        // Unwind to the bottom with restores that write caller outs.
        for (int k = 0; k < NW; k++) cyc("R7", 0, 1, 1, 10, 32'h9000 + k, 26, 18);
        for (int r = 1; r < 32; r += 2) cyc("R4", 0, 0, 0, 0, '0, r, r + 1 > 31 ? 0 : r + 1);
        summary();
    end
endmodule